// File: doc/BRIEF.md
# Processor Presence Map with Hot-Plug Event Interrupt

This block records which processors are present, one bit per processor firmware ID, and lets guest firmware read that record one byte at a time through an I/O window. When the platform adds or removes a processor, it sends an event carrying the ID and a plug or unplug flag. The block then updates the matching bit and latches a processor hot-plug flag in a general-purpose-event (GPE) status byte. A second event input latches a separate PCI hot-plug flag in the same byte.

A level-sensitive system control interrupt (SCI) is raised while either hot-plug flag is both latched and enabled, or while the externally computed fixed-event condition is true. Firmware services the interrupt in three steps: it reads the status byte, scans the presence map, and clears the flags it handled by writing ones to them. The GPE status and enable bytes share the I/O bus with the presence window, at their own addresses.

All I/O accesses are single bytes. A read returns its data on `io_rdata` in the cycle after the strobe. The register holds that value until the next read.

Top module: `chp_hotplug_sts`

## Requirements
- R1: After reset, the map holds the start-up presence mask given by parameter `BOOT_MASK`. The GPE status and enable bytes read 0x00, and `sci` is low while `fixed_sci` is low.
- R2: A read strobe (`io_cs`=1, `io_we`=0) at address `MAP_BASE`+k, with k from 0 to 31, returns map byte k one cycle later. Bit i of that byte is processor ID 8k+i, so the lowest ID is in the LSB. A read of any unmapped address returns 0x00. `io_rdata` changes only after a read strobe.
- R3: A plug event for ID n below 256 sets map bit n, and an unplug event clears it. No other map bit changes.
- R4: Writes into the map window leave every map byte unchanged.
- R5: An event whose ID is 256 or above changes neither the map nor the GPE status byte.
- R6: Each accepted processor event sets status bit 2 (0x04). A pulse on `pci_hp_evt` sets status bit 1 (0x02).
- R7: The GPE status byte is at `GPE_BASE`. Writing to it clears each bit written as 1 and leaves the bits written as 0.
- R8: The GPE enable byte is at `GPE_BASE`+2. A write replaces it, and a read returns it.
- R9: `sci` equals `fixed_sci` OR (status AND enable has bit 1 or bit 2 set). It follows a status or enable change in the cycle after the change is registered, and follows `fixed_sci` at once.
- R10: When an accepted processor event and a status write that clears bit 2 occur in the same cycle, bit 2 ends set.
- R11: Status bits 0 and 3 to 7 always read 0. Setting enable bits 0 and 3 to 7 never raises `sci`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_cs | input | 1 | I/O byte access strobe |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O byte address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, one cycle after the read strobe |
| cpu_evt_vld | input | 1 | Processor event strobe |
| cpu_evt_plug | input | 1 | 1 = plug, 0 = unplug |
| cpu_evt_id | input | 9 | Processor firmware ID |
| pci_hp_evt | input | 1 | PCI hot-plug event pulse |
| fixed_sci | input | 1 | Fixed-event interrupt condition |
| sci | output | 1 | Level system control interrupt |

## Verification
A wrong map bit does not show on any pin until firmware reads the byte that holds it. It then appears on `io_rdata` one cycle after that read strobe, so the bench reads every byte that an event could have disturbed, including the byte that a truncated out-of-range ID would land in. A wrong status bit shows on `sci` in the first cycle after the event edge when that bit is enabled, and otherwise only on a status read. For that reason, the interrupt level is checked under both enabled and disabled conditions.

// File: rtl/chp_pkg.sv
package chp_pkg;
    // status bit positions decoded by firmware
    localparam int PCI_HP_BIT = 1;
    localparam int CPU_HP_BIT = 2;
    localparam logic [7:0] SCI_SRC_MASK = 8'h06;

    typedef struct packed {
        logic [7:0] sts;
        logic [7:0] en;
    } gpe_regs_t;

    typedef struct packed {
        logic [7:0] rdata;
    } rd_port_t;
endpackage

// File: rtl/chp_presence_map.sv
module chp_presence_map #(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'hAF00,
    parameter int unsigned WIN_BYTES = 32,
    parameter int unsigned ID_W      = 9,
    parameter logic [WIN_BYTES*8-1:0] BOOT_MASK = 256'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              evt_vld,
    input  logic              evt_plug,
    input  logic [ID_W-1:0]   evt_id,
    output logic              rd_hit,
    output logic [7:0]        rd_byte,
    output logic              evt_ok
);
    localparam int unsigned NBITS = WIN_BYTES * 8;
    localparam int unsigned IDX_W = $clog2(NBITS);
    localparam int unsigned OFS_W = $clog2(WIN_BYTES);
    localparam logic [ID_W:0]     NBITS_L = (ID_W+1)'(NBITS);
    localparam logic [ADDR_W-1:0] WIN_L   = ADDR_W'(WIN_BYTES);

    typedef struct packed {
        logic [NBITS-1:0] map;
    } map_state_t;

    map_state_t state_d, state_q;
    logic [ADDR_W-1:0] ofs_full;
    logic [IDX_W-1:0]  bit_sel;

    always_comb begin
        ofs_full = rd_addr - BASE;
        rd_hit   = rd_req && (ofs_full < WIN_L);
        rd_byte  = state_q.map[{ofs_full[OFS_W-1:0], 3'b000} +: 8];
        evt_ok   = evt_vld && ({1'b0, evt_id} < NBITS_L);
        bit_sel  = evt_id[IDX_W-1:0];
        state_d  = state_q;
        if (evt_ok) begin
            state_d.map[bit_sel] = evt_plug;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.map <= BOOT_MASK;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/chp_gpe_regs.sv
module chp_gpe_regs
    import chp_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] GPE_BASE = 16'hAFE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_cs,
    input  logic              io_we,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              cpu_set,
    input  logic              pci_set,
    output logic              rd_hit,
    output logic [7:0]        rd_byte,
    output logic [7:0]        sts,
    output logic [7:0]        en
);
    localparam logic [ADDR_W-1:0] EN_ADDR = GPE_BASE + ADDR_W'(2);

    gpe_regs_t regs_d, regs_q;
    logic sts_sel, en_sel, sts_clr, en_wr, set_b;

    always_comb begin
        sts_sel = (io_addr == GPE_BASE);
        en_sel  = (io_addr == EN_ADDR);
        sts_clr = io_cs && io_we && sts_sel;
        en_wr   = io_cs && io_we && en_sel;
        rd_hit  = io_cs && !io_we && (sts_sel || en_sel);
        rd_byte = sts_sel ? regs_q.sts : regs_q.en;

        regs_d = regs_q;
        for (int b = 0; b < 8; b++) begin
            set_b = ((b == CPU_HP_BIT) && cpu_set) ||
                    ((b == PCI_HP_BIT) && pci_set);
            // a new event takes priority over a clear in the same cycle
            regs_d.sts[b] = set_b || (regs_q.sts[b] && !(sts_clr && io_wdata[b]));
        end
        if (en_wr) begin
            regs_d.en = io_wdata;
        end
        sts = regs_q.sts;
        en  = regs_q.en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/chp_sci_merge.sv
module chp_sci_merge
    import chp_pkg::*;
(
    input  logic [7:0] sts,
    input  logic [7:0] en,
    input  logic       fixed_sci,
    output logic       sci
);
    always_comb begin
        sci = fixed_sci || (|(sts & en & SCI_SRC_MASK));
    end
endmodule

// File: rtl/chp_hotplug_sts.sv
module chp_hotplug_sts
    import chp_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] MAP_BASE = 16'hAF00,
    parameter int unsigned MAP_BYTES = 32,
    parameter logic [ADDR_W-1:0] GPE_BASE = 16'hAFE0,
    parameter int unsigned ID_W      = 9,
    parameter logic [MAP_BYTES*8-1:0] BOOT_MASK = 256'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_cs,
    input  logic              io_we,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              cpu_evt_vld,
    input  logic              cpu_evt_plug,
    input  logic [ID_W-1:0]   cpu_evt_id,
    input  logic              pci_hp_evt,
    input  logic              fixed_sci,
    output logic              sci
);
    logic       rd_req;
    logic       map_hit, gpe_hit, cpu_evt_ok;
    logic [7:0] map_byte, gpe_byte, gpe_sts, gpe_en;
    rd_port_t   port_d, port_q;

    assign rd_req = io_cs && !io_we;

    chp_presence_map #(
        .ADDR_W(ADDR_W), .BASE(MAP_BASE), .WIN_BYTES(MAP_BYTES),
        .ID_W(ID_W), .BOOT_MASK(BOOT_MASK)
    ) u_map (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .rd_addr(io_addr),
        .evt_vld(cpu_evt_vld), .evt_plug(cpu_evt_plug), .evt_id(cpu_evt_id),
        .rd_hit(map_hit), .rd_byte(map_byte), .evt_ok(cpu_evt_ok)
    );

    chp_gpe_regs #(.ADDR_W(ADDR_W), .GPE_BASE(GPE_BASE)) u_gpe (
        .clk(clk), .rst_n(rst_n),
        .io_cs(io_cs), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
        .cpu_set(cpu_evt_ok), .pci_set(pci_hp_evt),
        .rd_hit(gpe_hit), .rd_byte(gpe_byte), .sts(gpe_sts), .en(gpe_en)
    );

    chp_sci_merge u_sci (
        .sts(gpe_sts), .en(gpe_en), .fixed_sci(fixed_sci), .sci(sci)
    );

    always_comb begin
        port_d = port_q;
        if (rd_req) begin
            if (map_hit) begin
                port_d.rdata = map_byte;
            end else if (gpe_hit) begin
                port_d.rdata = gpe_byte;
            end else begin
                port_d.rdata = 8'h00;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign io_rdata = port_q.rdata;
endmodule

// File: rtl/chp_hotplug_sts_sva.sv
module chp_hotplug_sts_sva #(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] GPE_BASE = 16'hAFE0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_cs,
    input logic              io_we,
    input logic [ADDR_W-1:0] io_addr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              cpu_evt_vld,
    input logic              pci_hp_evt,
    input logic              sci,
    input logic [7:0]        gpe_sts,
    input logic [7:0]        gpe_en,
    input logic              evt_ok
);
    localparam logic [ADDR_W-1:0] EN_ADDR = GPE_BASE + ADDR_W'(2);

    logic sts_wr, en_wr;
    assign sts_wr = io_cs && io_we && (io_addr == GPE_BASE);
    assign en_wr  = io_cs && io_we && (io_addr == EN_ADDR);

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_cs && !io_we) |=> $stable(io_rdata)); // R2

    AST_BAD_ID_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_evt_vld && !evt_ok && !pci_hp_evt && !sts_wr) |=> $stable(gpe_sts)); // R5

    AST_EVT_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ok |=> gpe_sts[2]); // R6

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && !evt_ok && !pci_hp_evt) |=> ((gpe_sts & $past(io_wdata)) == 8'h00)); // R7

    AST_SCI_AFTER_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ok && gpe_en[2] && !en_wr) |=> sci); // R9

    AST_EVT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ok && sts_wr && io_wdata[2]) |=> gpe_sts[2]); // R10

    AST_STS_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (gpe_sts & 8'hF9) == 8'h00); // R11
endmodule

bind chp_hotplug_sts chp_hotplug_sts_sva #(.ADDR_W(ADDR_W), .GPE_BASE(GPE_BASE)) u_sva (
    .clk(clk), .rst_n(rst_n), .io_cs(io_cs), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_evt_vld(cpu_evt_vld),
    .pci_hp_evt(pci_hp_evt), .sci(sci), .gpe_sts(gpe_sts), .gpe_en(gpe_en),
    .evt_ok(cpu_evt_ok)
);

// File: tb/chp_hotplug_sts_bench.sv
`timescale 1ns/1ps
module chp_hotplug_sts_bench;
    localparam logic [15:0] MAP = 16'hAF00;
    localparam logic [15:0] GPE = 16'hAFE0;
    localparam logic [255:0] BOOT = 256'h0203; // IDs 0, 1, 9 present

    logic clk = 0, rst_n = 0;
    logic io_cs = 0, io_we = 0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0, io_rdata;
    logic cpu_evt_vld = 0, cpu_evt_plug = 0, pci_hp_evt = 0, fixed_sci = 0, sci;
    logic [8:0] cpu_evt_id = '0;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [255:0] exp_map;
    logic [7:0] exp_sts = 0, exp_en = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];
    logic rd_seen = 0;

    always #4 clk = ~clk;

    chp_hotplug_sts #(.BOOT_MASK(BOOT)) u_chp_hotplug_sts (
        .clk(clk), .rst_n(rst_n), .io_cs(io_cs), .io_we(io_we), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_evt_vld(cpu_evt_vld),
        .cpu_evt_plug(cpu_evt_plug), .cpu_evt_id(cpu_evt_id),
        .pci_hp_evt(pci_hp_evt), .fixed_sci(fixed_sci), .sci(sci)
    );

    // monitor: pops one expected byte per completed read
    always @(posedge clk) rd_seen <= io_cs && !io_we && rst_n;
    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read data actual=%02h expected=none", io_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (io_rdata !== e) begin
                    errors++;
                    $display("FAIL %s read actual=%02h expected=%02h", t, io_rdata, e);
                end
            end
        end
    end

    task automatic io_rd(input logic [15:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        io_cs = 1; io_we = 0; io_addr = a;
        @(negedge clk);
        io_cs = 0;
    endtask

    task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
        io_cs = 1; io_we = 1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_cs = 0; io_we = 0;
        if (a == GPE) exp_sts = exp_sts & ~d;
        if (a == GPE + 16'd2) exp_en = d;
    endtask

    task automatic cpu_evt(input bit plug, input int id);
        cpu_evt_vld = 1; cpu_evt_plug = plug; cpu_evt_id = 9'(id);
        @(negedge clk);
        cpu_evt_vld = 0;
        if (id < 256) begin
            exp_map[id] = plug;
            exp_sts[2] = 1'b1;
        end
    endtask

    task automatic pci_evt();
        pci_hp_evt = 1;
        @(negedge clk);
        pci_hp_evt = 0;
        exp_sts[1] = 1'b1;
    endtask

    task automatic chk_sci(input string t);
        logic e;
        #1;
        e = fixed_sci | (|(exp_sts & exp_en & 8'h06));
        checks++;
        if (sci !== e) begin
            errors++;
            $display("FAIL %s sci actual=%0b expected=%0b", t, sci, e);
        end
    endtask

    task automatic rd_map(input int k, input string t);
        io_rd(MAP + 16'(k), exp_map[k*8 +: 8], t);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        exp_map = BOOT;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_sci("R1");
        for (int k = 0; k < 32; k++) rd_map(k, "R1");
        io_rd(GPE, 8'h00, "R1");
        io_rd(GPE + 16'd2, 8'h00, "R1");

        // R3 plug / unplug
        cpu_evt(1, 5); cpu_evt(1, 200); cpu_evt(1, 255); cpu_evt(1, 8);
        cpu_evt(0, 1); cpu_evt(1, 9);
        rd_map(0, "R3"); rd_map(1, "R3"); rd_map(25, "R3"); rd_map(31, "R3");
        cpu_evt(0, 255);
        rd_map(31, "R3"); rd_map(30, "R3");

        // R2 unmapped reads return zero
        io_rd(16'hAEFF, 8'h00, "R2");
        io_rd(16'hAF20, 8'h00, "R2");
        io_rd(16'h0000, 8'h00, "R2");
        rd_map(25, "R2");

        // R4 writes to the window ignored
        io_wr(MAP, 8'hFF); io_wr(MAP + 16'd31, 8'hFF); io_wr(MAP + 16'd1, 8'h00);
        rd_map(0, "R4"); rd_map(1, "R4"); rd_map(31, "R4");

        // R6 status flags
        io_rd(GPE, 8'h04, "R6");
        pci_evt();
        io_rd(GPE, 8'h06, "R6");

        // R7 write-one-to-clear
        io_wr(GPE, 8'h00); io_rd(GPE, 8'h06, "R7");
        io_wr(GPE, 8'h02); io_rd(GPE, 8'h04, "R7");
        io_wr(GPE, 8'hFF); io_rd(GPE, 8'h00, "R7");

        // R5 out-of-range IDs (265 would alias ID 9 if truncated)
        cpu_evt(0, 265); cpu_evt(1, 300);
        rd_map(1, "R5"); rd_map(5, "R5");
        io_rd(GPE, 8'h00, "R5");

        // R8 enable register
        io_wr(GPE + 16'd2, 8'hA5); io_rd(GPE + 16'd2, 8'hA5, "R8");

        // R9 interrupt level
        io_wr(GPE + 16'd2, 8'h04); chk_sci("R9");
        cpu_evt(1, 2); chk_sci("R9");
        io_wr(GPE, 8'h04); chk_sci("R9");
        io_wr(GPE + 16'd2, 8'h02); pci_evt(); chk_sci("R9");
        io_wr(GPE + 16'd2, 8'h00); chk_sci("R9");
        io_wr(GPE + 16'd2, 8'h02); chk_sci("R9");
        io_wr(GPE, 8'h02); chk_sci("R9");
        fixed_sci = 1; chk_sci("R9");
        @(negedge clk); fixed_sci = 0; chk_sci("R9");

        // R11 reserved bits
        io_wr(GPE + 16'd2, 8'hF9);
        cpu_evt(1, 3); chk_sci("R11");
        io_rd(GPE, 8'h04, "R11");
        rd_map(0, "R3");
        io_wr(GPE, 8'hFF);

        // R10 event beats clear in the same cycle
        io_wr(GPE + 16'd2, 8'h00);
        io_cs = 1; io_we = 1; io_addr = GPE; io_wdata = 8'h04;
        cpu_evt_vld = 1; cpu_evt_plug = 1; cpu_evt_id = 9'd7;
        @(negedge clk);
        io_cs = 0; io_we = 0; cpu_evt_vld = 0;
        exp_map[7] = 1'b1; exp_sts[2] = 1'b1;
        io_rd(GPE, 8'h04, "R10");
        rd_map(0, "R10");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 pending reads actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule